// File: doc/BRIEF.md
# Dual-Mode Interval Timer

A 16-bit down-counting interval timer with a separate 16-bit reload latch, driven from an 8-bit register bus. Software reaches both the latch and the live counter one byte at a time. Writing the upper byte through the counter window starts a timing run. The run loads the whole latch value into the counter, clears the pending interrupt and arms the timer.

Two modes are available. In one-shot mode the timer raises its interrupt flag once, when the count runs out. After that the counter keeps decrementing and wraps without flagging again until software reloads it. In free-run mode the counter wraps past zero and reloads from the latch. This gives interrupts at a fixed spacing of the latch value plus two cycles. The flag goes to an active-low interrupt output through an enable bit, and a read of the low counter byte clears it.

Top module: `itmr_top`

## Requirements
- R1: After reset the interrupt flag, the enable bit and the mode bit are 0, `irq_no` is high, the latch reads 0, and the control (address 4) and status (address 5) registers read 0.
- R2: When the counter is neither being loaded nor reloaded, it decrements by one on every clock. Reads at address 0 return its low byte and reads at address 1 return its high byte.
- R3: A write to address 1 stores the data in the latch high byte and, on the same edge, loads the counter with {write data, latch low byte}. It also clears the flag and arms the timer.
- R4: Writes to address 2 (latch low) and address 3 (latch high) change only the latch, which reads back at those addresses. A write to address 0 also sets the latch low byte. None of these writes change the counter or the flag.
- R5: In one-shot mode (control bit 0 = 0), the flag sets on the edge N+1 cycles after a load of value N. It does not set again before the next load, even when the counter wraps.
- R6: In free-run mode (control bit 0 = 1), the counter goes from 0 to 0xFFFF, and on the next edge it reloads the latch. The first flag comes N+1 cycles after the load and each later flag N+2 cycles after the one before.
- R7: The flag (status bit 0) clears when address 0 is read, or when 1 is written to status bit 0. Writing 0 there leaves it unchanged. A set event in the same cycle wins over a clear.
- R8: `irq_no` is low exactly when the flag and the enable bit (control bit 1) are both 1. Clearing the enable bit leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while sel_i is high and wr_i is low |
| irq_no | output | 1 | Active-low interrupt |

## Verification
Directed loads of small values (3, 5, 10) pin down the exact edge of the first flag and the one-cycle wrap-then-reload gap. A long one-shot watch through a full 16-bit wrap tells the one-shot behaviour apart from the periodic one. Randomized loads with a random mode and lengths between 3 and 152 check the first interval (N+1) and the later intervals (N+2) against bench functions. This catches off-by-one errors in the reload path. Byte reads taken before and after latch writes tell a latch-only write apart from one that disturbs the counter. Toggling the enable bit while a flag is pending separates masking from clearing.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_LAT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_LAT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;

  localparam int unsigned CTRL_MODE_BIT = 0;
  localparam int unsigned CTRL_IE_BIT   = 1;
  localparam int unsigned STAT_FLAG_BIT = 0;

  typedef struct packed {
    logic load;
    logic lat_lo_wr;
    logic lat_hi_wr;
    logic ctrl_wr;
    logic stat_wr;
    logic cnt_rd;
  } bus_strb_t;
endpackage

// File: rtl/itmr_bus_dec.sv
module itmr_bus_dec
  import itmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  lat_i,
  input  logic              mode_i,
  input  logic              ie_i,
  input  logic              flag_i,
  output bus_strb_t         strb_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic wr_en, rd_en;
  assign wr_en = sel_i & wr_i;
  assign rd_en = sel_i & ~wr_i;

  always_comb begin
    strb_o           = '0;
    strb_o.load      = wr_en && (addr_i == A_CNT_HI);
    strb_o.lat_lo_wr = wr_en && (addr_i == A_CNT_LO || addr_i == A_LAT_LO);
    strb_o.lat_hi_wr = wr_en && (addr_i == A_CNT_HI || addr_i == A_LAT_HI);
    strb_o.ctrl_wr   = wr_en && (addr_i == A_CTRL);
    strb_o.stat_wr   = wr_en && (addr_i == A_STAT);
    strb_o.cnt_rd    = rd_en && (addr_i == A_CNT_LO);
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      case (addr_i)
        A_CNT_LO: rdata_o = cnt_i[DATA_W-1:0];
        A_CNT_HI: rdata_o = cnt_i[CNT_W-1:DATA_W];
        A_LAT_LO: rdata_o = lat_i[DATA_W-1:0];
        A_LAT_HI: rdata_o = lat_i[CNT_W-1:DATA_W];
        A_CTRL: begin
          rdata_o[CTRL_MODE_BIT] = mode_i;
          rdata_o[CTRL_IE_BIT]   = ie_i;
        end
        A_STAT: rdata_o[STAT_FLAG_BIT] = flag_i;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/itmr_core.sv
module itmr_core
  import itmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_strb_t         strb_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              free_run_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  lat_o,
  output logic              armed_o,
  output logic              wrap_o,
  output logic              hit_o
);
  logic [CNT_W-1:0] cnt_q, lat_q;
  logic             armed_q, wrap_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      wrap_q  <= 1'b0;
    end else begin
      if (strb_i.lat_lo_wr) lat_q[DATA_W-1:0]     <= wdata_i;
      if (strb_i.lat_hi_wr) lat_q[CNT_W-1:DATA_W] <= wdata_i;
      if (strb_i.load) begin
        cnt_q   <= {wdata_i, lat_q[DATA_W-1:0]};
        armed_q <= 1'b1;
        wrap_q  <= 1'b0;
      end else if (wrap_q && free_run_i) begin
        cnt_q  <= lat_q;
        wrap_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
        wrap_q <= at_zero;
        // one-shot: disarm after the single expiry
        if (at_zero && !free_run_i) armed_q <= 1'b0;
      end
    end
  end

  assign hit_o   = at_zero && armed_q && !strb_i.load;
  assign cnt_o   = cnt_q;
  assign lat_o   = lat_q;
  assign armed_o = armed_q;
  assign wrap_o  = wrap_q;
endmodule

// File: rtl/itmr_irq.sv
module itmr_irq
  import itmr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  bus_strb_t strb_i,
  input  logic      mode_d_i,
  input  logic      ie_d_i,
  input  logic      clr_d_i,
  input  logic      hit_i,
  output logic      mode_o,
  output logic      ie_o,
  output logic      flag_o,
  output logic      irq_no
);
  logic mode_q, ie_q, flag_q, clr_req;

  assign clr_req = strb_i.load | strb_i.cnt_rd | (strb_i.stat_wr & clr_d_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (strb_i.ctrl_wr) begin
        mode_q <= mode_d_i;
        ie_q   <= ie_d_i;
      end
      if (hit_i)        flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
    end
  end

  assign mode_o = mode_q;
  assign ie_o   = ie_q;
  assign flag_o = flag_q;
  assign irq_no = ~(flag_q & ie_q);
endmodule

// File: rtl/itmr_top.sv
module itmr_top
  import itmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_no
);
  bus_strb_t        strb;
  logic [CNT_W-1:0] cnt, lat;
  logic             armed, wrap, hit, mode, ie, flag;

  itmr_bus_dec #(.DATA_W(DATA_W)) u_dec (
    .sel_i  (sel_i),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .cnt_i  (cnt),
    .lat_i  (lat),
    .mode_i (mode),
    .ie_i   (ie),
    .flag_i (flag),
    .strb_o (strb),
    .rdata_o(rdata_o)
  );

  itmr_core #(.DATA_W(DATA_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strb_i    (strb),
    .wdata_i   (wdata_i),
    .free_run_i(mode),
    .cnt_o     (cnt),
    .lat_o     (lat),
    .armed_o   (armed),
    .wrap_o    (wrap),
    .hit_o     (hit)
  );

  itmr_irq u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strb_i  (strb),
    .mode_d_i(wdata_i[CTRL_MODE_BIT]),
    .ie_d_i  (wdata_i[CTRL_IE_BIT]),
    .clr_d_i (wdata_i[STAT_FLAG_BIT]),
    .hit_i   (hit),
    .mode_o  (mode),
    .ie_o    (ie),
    .flag_o  (flag),
    .irq_no  (irq_no)
  );
endmodule

// File: rtl/itmr_chk.sv
module itmr_chk
  import itmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_no,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  lat,
  input logic              armed,
  input logic              wrap,
  input logic              hit,
  input logic              mode,
  input logic              ie,
  input logic              flag
);
  logic load_w;
  assign load_w = sel_i && wr_i && (addr_i == A_CNT_HI);

  AST_LOAD_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_w |=> (cnt == {$past(wdata_i), $past(lat[DATA_W-1:0])}) && armed && !flag); // R3

  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_w && !(wrap && mode)) |=> cnt == $past(cnt) - 1'b1); // R2

  AST_FREE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && mode && !load_w) |=> cnt == $past(lat)); // R6

  AST_SINGLE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag) |-> $past(armed)); // R5

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_i && addr_i == A_CNT_LO && !hit) |=> !flag); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie |-> irq_no); // R8
endmodule

bind itmr_top itmr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sel_i  (sel_i),
  .wr_i   (wr_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .irq_no (irq_no),
  .cnt    (cnt),
  .lat    (lat),
  .armed  (armed),
  .wrap   (wrap),
  .hit    (hit),
  .mode   (mode),
  .ie     (ie),
  .flag   (flag)
);

// File: tb/itmr_top_tb_top.sv
module itmr_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq_n;
  int         cyc = 0;
  int         total = 0;
  int         bad = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  itmr_top dut_i (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .wr_i   (wr),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_no (irq_n)
  );

  function automatic int exp_first(input int n);
    return n + 1;
  endfunction

  function automatic int exp_period(input int n);
    return n + 2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a negedge
  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic load(input int n);
    bus_wr(3'd2, n[7:0]);
    bus_wr(3'd1, n[15:8]);
  endtask

  task automatic wait_irq(output int at, input int limit);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      if (irq_n == 1'b0) begin at = cyc; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d, c0;
    int t0, t1, t2, n, viol;
    logic m;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    chk("R1 irq_no", int'(irq_n), 1);
    bus_rd(3'd4, d); chk("R1 ctrl", int'(d), 0);
    bus_rd(3'd5, d); chk("R1 status", int'(d), 0);
    bus_rd(3'd2, d); chk("R1 latch lo", int'(d), 0);

    bus_wr(3'd4, 8'h02); // enable, one-shot
    load(16'h1234);
    bus_rd(3'd0, d); chk("R3 cnt lo after load", int'(d), 8'h34);
    bus_rd(3'd0, d); chk("R2 cnt lo decrement", int'(d), 8'h33);
    bus_rd(3'd1, d); chk("R2 cnt hi", int'(d), 8'h12);
    bus_rd(3'd3, d); chk("R4 latch hi", int'(d), 8'h12);
    bus_rd(3'd2, d); chk("R4 latch lo", int'(d), 8'h34);

    bus_rd(3'd0, c0);
    bus_wr(3'd2, 8'h55);
    bus_rd(3'd0, d); chk("R4 cnt untouched by latch write", int'(d), int'(8'(c0 - 8'd2)));
    bus_rd(3'd2, d); chk("R4 latch lo readback", int'(d), 8'h55);
    bus_wr(3'd3, 8'h66);
    bus_rd(3'd1, d); chk("R4 cnt hi untouched", int'(d), 8'h12);
    chk("R4 no flag", int'(irq_n), 1);

    // one-shot, directed
    load(10); t0 = cyc;
    wait_irq(t1, 500);
    chk("R5 one-shot first flag", t1 - t0, exp_first(10));
    bus_rd(3'd5, d); chk("R7 status flag set", int'(d), 1);
    bus_wr(3'd5, 8'h00);
    chk("R7 write 0 keeps flag", int'(irq_n), 0);
    bus_wr(3'd5, 8'h01);
    chk("R7 write 1 clears flag", int'(irq_n), 1);
    viol = 0;
    for (int i = 0; i < 65600; i++) begin
      if (irq_n == 1'b0) viol++;
      @(negedge clk);
    end
    chk("R5 no second flag across wrap", viol, 0);

    // enable masking
    load(5);
    wait_irq(t1, 200);
    bus_wr(3'd4, 8'h00);
    chk("R8 masked irq high", int'(irq_n), 1);
    bus_rd(3'd5, d); chk("R8 flag kept while masked", int'(d), 1);
    bus_wr(3'd4, 8'h02);
    chk("R8 unmasked irq low", int'(irq_n), 0);
    bus_rd(3'd0, d);
    chk("R7 read cnt lo clears flag", int'(irq_n), 1);

    // free-run, directed
    bus_wr(3'd4, 8'h03);
    load(3); t0 = cyc;
    wait_irq(t1, 200);
    chk("R6 free-run first flag", t1 - t0, exp_first(3));
    bus_rd(3'd0, d); chk("R6 wrap value", int'(d), 8'hFF);
    bus_rd(3'd0, d); chk("R6 reload value", int'(d), 3);
    wait_irq(t2, 200);
    chk("R6 free-run period", t2 - t1, exp_period(3));
    bus_wr(3'd5, 8'h01);
    wait_irq(t0, 200);
    chk("R6 free-run period again", t0 - t2, exp_period(3));

    // random loads and modes
    for (int k = 0; k < 12; k++) begin
      m = 1'($urandom % 2);
      n = 3 + int'($urandom % 150);
      bus_wr(3'd4, {6'd0, 1'b1, m});
      load(n); t0 = cyc;
      wait_irq(t1, 1000);
      chk("R5/R6 random first flag", t1 - t0, exp_first(n));
      bus_wr(3'd5, 8'h01);
      if (m) begin
        wait_irq(t2, 1000);
        chk("R6 random period", t2 - t1, exp_period(n));
      end else begin
        viol = 0;
        for (int i = 0; i < n + 10; i++) begin
          if (irq_n == 1'b0) viol++;
          @(negedge clk);
        end
        chk("R5 random single flag", viol, 0);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule